// File: doc/BRIEF.md
# Condition-Register Load Steering Unit

This unit sits at the load dispatch point of an out-of-order core. It decides, load by load, whether the load takes a load-queue entry and the address cross-check against older stores, or skips both. The compiler supplies that decision through a small file of one-bit condition registers. A compare-and-set operation writes one of these registers. An extended "safe" load names one register, and the unit reads it when the load is presented. Register 0 always reads true, so software can mark a load that it has proven safe without spending a register. An indirect jump clears the whole file in one cycle, because the compiler's reasoning no longer holds once control leaves the analysed region.

A second way to call a load safe follows the store queue. Each dispatched store carries a flag that says whether software has shown it cannot feed a later load. The unit keeps that flag for every store-queue slot, along with a count of unsafe stores still in flight. A load that asks for the scope test is safe only when that count is zero. Two running counters record how many loads skipped the load queue and how many were queued, so that the bypass ratio can be read out.

Top module: `safe_load_steer`

## Requirements
- R1: After reset every condition register except index 0 reads false, the unsafe-store count is zero, `scope_safe` is 1, and both load counters are zero.
- R2: A compare-and-set (`cset_valid`) writes `cset_value` into register `cset_idx` for indices 1 to NUM_CR-1. Loads see the new value from the following cycle on. A load in the same cycle sees the old value.
- R3: Register index 0 always reads true, and a compare-and-set that targets index 0 changes nothing.
- R4: `flash_clr` clears every register with index 1 to NUM_CR-1 to false for loads in the next cycle. If a compare-and-set arrives in the same cycle, the clear wins.
- R5: A load presented with `ld_safe_op`=1 is safe in one of two cases: `ld_scope`=0 and the named register is true, or `ld_scope`=1 and the unsafe-store count is zero. A safe load has `ld_ready`=1 and pulses `ld_bypass` even when `lq_full`=1. It never pulses `ld_enq`.
- R6: A load that is not safe, including any load with `ld_safe_op`=0, has `ld_ready` = !`lq_full`. It pulses `ld_enq` only when accepted, and it never pulses `ld_bypass`.
- R7: Dispatching a store into a free slot with `st_disp_safe`=0 raises `unsafe_stores` by one in the next cycle. Retiring or squashing an occupied slot that holds an unsafe store lowers it by one. Safe stores leave the count unchanged. Events in one cycle add up.
- R8: `scope_safe` is 1 exactly when `unsafe_stores` is zero.
- R9: `safe_cnt` grows by one in the cycle after each `ld_bypass`, and `queued_cnt` grows by one in the cycle after each `ld_enq`.
- R10: The following store events change nothing: a dispatch to an occupied slot, a retire or squash of an empty slot, and a squash of the same slot that is being retired in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cset_valid | input | 1 | Compare-and-set write strobe |
| cset_idx | input | CR_W | Register written |
| cset_value | input | 1 | Boolean result to store |
| flash_clr | input | 1 | Indirect jump: clear all writable registers |
| ld_valid | input | 1 | Load presented at dispatch |
| ld_safe_op | input | 1 | Load is an extended safe load |
| ld_scope | input | 1 | Judge by store scope instead of a register |
| ld_cr | input | CR_W | Register index named by the load |
| lq_full | input | 1 | Load queue has no free entry |
| ld_ready | output | 1 | Load can be accepted this cycle |
| ld_bypass | output | 1 | Accepted load skips the load queue |
| ld_enq | output | 1 | Accepted load takes a load-queue entry |
| st_disp_valid | input | 1 | Store dispatched |
| st_disp_tag | input | SQ_W | Store-queue slot of dispatched store |
| st_disp_safe | input | 1 | Dispatched store is proven safe |
| st_ret_valid | input | 1 | Store retired |
| st_ret_tag | input | SQ_W | Slot of retired store |
| st_squash_valid | input | 1 | Store squashed |
| st_squash_tag | input | SQ_W | Slot of squashed store |
| unsafe_stores | output | UC_W | Unsafe stores in flight |
| scope_safe | output | 1 | No unsafe store in flight |
| safe_cnt | output | CNT_W | Loads that bypassed the load queue |
| queued_cnt | output | CNT_W | Loads sent to the load queue |

## Verification
The bench builds the unit with eight condition registers and an eight-slot store queue. With these sizes it can write and read back every register with both values and try every index against the hard-wired true register. It can also fill the store queue completely with a mix of safe and unsafe stores and then empty it through retires and squashes. The bench also combines dispatch, retire and squash in one cycle, clears the file while a write is pending, and tries loads against a full load queue. It compares the bypass and queue counters against its own count of accepted loads.

// File: rtl/safe_load_steer.sv
module safe_load_steer #(
  parameter int NUM_CR   = 8,
  parameter int SQ_DEPTH = 48,
  parameter int CNT_W    = 16,
  localparam int CR_W = (NUM_CR > 1) ? $clog2(NUM_CR) : 1,
  localparam int SQ_W = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1,
  localparam int UC_W = $clog2(SQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cset_valid,
  input  logic [CR_W-1:0]  cset_idx,
  input  logic             cset_value,
  input  logic             flash_clr,
  input  logic             ld_valid,
  input  logic             ld_safe_op,
  input  logic             ld_scope,
  input  logic [CR_W-1:0]  ld_cr,
  input  logic             lq_full,
  output logic             ld_ready,
  output logic             ld_bypass,
  output logic             ld_enq,
  input  logic             st_disp_valid,
  input  logic [SQ_W-1:0]  st_disp_tag,
  input  logic             st_disp_safe,
  input  logic             st_ret_valid,
  input  logic [SQ_W-1:0]  st_ret_tag,
  input  logic             st_squash_valid,
  input  logic [SQ_W-1:0]  st_squash_tag,
  output logic [UC_W-1:0]  unsafe_stores,
  output logic             scope_safe,
  output logic [CNT_W-1:0] safe_cnt,
  output logic [CNT_W-1:0] queued_cnt
);

  logic [NUM_CR-1:1] cr_q;
  logic [NUM_CR-1:0] cr_file;
  logic              cr_hit, ld_safe;
  logic              cset_ok;

  assign cr_file = {cr_q, 1'b1};
  assign cset_ok = cset_valid && (cset_idx != '0) &&
                   ({1'b0, cset_idx} < (CR_W+1)'(NUM_CR));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         cr_q <= '0;
    else if (flash_clr) cr_q <= '0;
    else if (cset_ok)   cr_q[cset_idx] <= cset_value;

  assign cr_hit = ({1'b0, ld_cr} < (CR_W+1)'(NUM_CR)) && cr_file[ld_cr];

  logic [SQ_DEPTH-1:0] st_live, st_unsafe;
  logic [UC_W-1:0]     unsafe_q;
  logic                disp_ok, ret_ok, sq_ok;
  logic                inc_u, dec_r, dec_s;

  assign disp_ok = st_disp_valid && !st_live[st_disp_tag];
  assign ret_ok  = st_ret_valid && st_live[st_ret_tag];
  assign sq_ok   = st_squash_valid && st_live[st_squash_tag] &&
                   !(st_ret_valid && st_ret_tag == st_squash_tag);
  assign inc_u   = disp_ok && !st_disp_safe;
  assign dec_r   = ret_ok && st_unsafe[st_ret_tag];
  assign dec_s   = sq_ok && st_unsafe[st_squash_tag];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_live   <= '0;
      st_unsafe <= '0;
      unsafe_q  <= '0;
    end else begin
      for (int i = 0; i < SQ_DEPTH; i++) begin
        if ((ret_ok && st_ret_tag == SQ_W'(i)) || (sq_ok && st_squash_tag == SQ_W'(i))) begin
          st_live[i]   <= 1'b0;
          st_unsafe[i] <= 1'b0;
        end else if (disp_ok && st_disp_tag == SQ_W'(i)) begin
          st_live[i]   <= 1'b1;
          st_unsafe[i] <= !st_disp_safe;
        end
      end
      unsafe_q <= unsafe_q + UC_W'(inc_u) - UC_W'(dec_r) - UC_W'(dec_s);
    end

  assign unsafe_stores = unsafe_q;
  assign scope_safe    = (unsafe_q == '0);

  assign ld_safe   = ld_safe_op && (ld_scope ? scope_safe : cr_hit);
  assign ld_ready  = ld_safe || !lq_full;
  assign ld_bypass = ld_valid && ld_safe;
  assign ld_enq    = ld_valid && !ld_safe && !lq_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      safe_cnt   <= '0;
      queued_cnt <= '0;
    end else begin
      if (ld_bypass) safe_cnt   <= safe_cnt + 1'b1;
      if (ld_enq)    queued_cnt <= queued_cnt + 1'b1;
    end

  // R4
  cr_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_clr |=> (cr_q == '0));

  // R2
  cr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cset_ok && !flash_clr) |=> (cr_file[$past(cset_idx)] == $past(cset_value)));

  // R3
  cr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_safe_op && !ld_scope && ld_cr == '0) |-> ld_bypass);

  // R6
  ld_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_bypass, ld_enq}));

  // R7
  unsafe_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(st_unsafe) == int'(unsafe_q));

  // R7
  unsafe_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(unsafe_q) <= SQ_DEPTH);

  // R9
  safe_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_bypass |=> (safe_cnt == CNT_W'($past(safe_cnt) + 1'b1)));

  // R9
  queued_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_enq |=> (queued_cnt == CNT_W'($past(queued_cnt) + 1'b1)));

endmodule

// File: tb/test_safe_load_steer.sv
`timescale 1ns/1ps
module test_safe_load_steer;
  localparam int NCR = 8;
  localparam int SQD = 8;

  logic clk = 0, rst_n = 0;
  logic cset_valid, cset_value, flash_clr;
  logic [2:0] cset_idx, ld_cr;
  logic ld_valid, ld_safe_op, ld_scope, lq_full;
  logic ld_ready, ld_bypass, ld_enq;
  logic st_disp_valid, st_disp_safe, st_ret_valid, st_squash_valid;
  logic [2:0] st_disp_tag, st_ret_tag, st_squash_tag;
  logic [3:0] unsafe_stores;
  logic scope_safe;
  logic [15:0] safe_cnt, queued_cnt;

  safe_load_steer #(.NUM_CR(NCR), .SQ_DEPTH(SQD), .CNT_W(16)) i_safe_load_steer (
    .clk(clk), .rst_n(rst_n), .cset_valid(cset_valid), .cset_idx(cset_idx),
    .cset_value(cset_value), .flash_clr(flash_clr), .ld_valid(ld_valid),
    .ld_safe_op(ld_safe_op), .ld_scope(ld_scope), .ld_cr(ld_cr), .lq_full(lq_full),
    .ld_ready(ld_ready), .ld_bypass(ld_bypass), .ld_enq(ld_enq),
    .st_disp_valid(st_disp_valid), .st_disp_tag(st_disp_tag), .st_disp_safe(st_disp_safe),
    .st_ret_valid(st_ret_valid), .st_ret_tag(st_ret_tag),
    .st_squash_valid(st_squash_valid), .st_squash_tag(st_squash_tag),
    .unsafe_stores(unsafe_stores), .scope_safe(scope_safe),
    .safe_cnt(safe_cnt), .queued_cnt(queued_cnt));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit cr_m[NCR];
  bit live_m[SQD], uns_m[SQD];
  int ucnt_m = 0, sc_m = 0, qc_m = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    cset_valid = 0; cset_idx = 0; cset_value = 0; flash_clr = 0;
    ld_valid = 0; ld_safe_op = 0; ld_scope = 0; ld_cr = 0; lq_full = 0;
    st_disp_valid = 0; st_disp_tag = 0; st_disp_safe = 0;
    st_ret_valid = 0; st_ret_tag = 0; st_squash_valid = 0; st_squash_tag = 0;
  endtask

  task automatic cset(input int idx, input bit val, input bit clr);
    @(negedge clk);
    cset_valid = 1; cset_idx = idx[2:0]; cset_value = val; flash_clr = clr;
    @(posedge clk); #1;
    if (clr) for (int i = 1; i < NCR; i++) cr_m[i] = 0;
    else if (idx != 0) cr_m[idx] = val;
    idle();
  endtask

  task automatic load(input bit sop, input bit scp, input int cr, input bit full, input string req);
    bit s;
    @(negedge clk);
    ld_valid = 1; ld_safe_op = sop; ld_scope = scp; ld_cr = cr[2:0]; lq_full = full;
    #1;
    s = sop && (scp ? (ucnt_m == 0) : cr_m[cr]);
    chk(req, "ld_ready", ld_ready, s || !full);
    chk(req, "ld_bypass", ld_bypass, s);
    chk(req, "ld_enq", ld_enq, !s && !full);
    @(posedge clk); #1;
    if (s) sc_m++; else if (!full) qc_m++;
    idle();
  endtask

  task automatic store(input bit dv, input int dt, input bit ds,
                       input bit rv, input int rt, input bit sv, input int stg);
    bit d_ok, r_ok, s_ok;
    @(negedge clk);
    st_disp_valid = dv; st_disp_tag = dt[2:0]; st_disp_safe = ds;
    st_ret_valid = rv; st_ret_tag = rt[2:0]; st_squash_valid = sv; st_squash_tag = stg[2:0];
    @(posedge clk); #1;
    d_ok = dv && !live_m[dt];
    r_ok = rv && live_m[rt];
    s_ok = sv && live_m[stg] && !(rv && rt == stg);
    if (d_ok && !ds) ucnt_m++;
    if (r_ok && uns_m[rt]) ucnt_m--;
    if (s_ok && uns_m[stg]) ucnt_m--;
    if (r_ok) begin live_m[rt] = 0; uns_m[rt] = 0; end
    if (s_ok) begin live_m[stg] = 0; uns_m[stg] = 0; end
    if (d_ok) begin live_m[dt] = 1; uns_m[dt] = !ds; end
    idle();
  endtask

  task automatic state(input string req);
    chk(req, "unsafe_stores", unsafe_stores, ucnt_m);
    chk("R8", "scope_safe", scope_safe, ucnt_m == 0);
    chk("R9", "safe_cnt", safe_cnt, sc_m);
    chk("R9", "queued_cnt", queued_cnt, qc_m);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    cr_m[0] = 1;
    for (int i = 1; i < NCR; i++) cr_m[i] = 0;
    for (int i = 0; i < SQD; i++) begin live_m[i] = 0; uns_m[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 state("R1");
    // R1 / R3: reset file contents through loads
    for (int i = 0; i < NCR; i++) load(1, 0, i, 0, (i == 0) ? "R3" : "R1");
    // R2: every register with both values, and same-cycle read of old value
    for (int i = 1; i < NCR; i++) begin
      for (int v = 1; v >= 0; v--) begin
        @(negedge clk);
        cset_valid = 1; cset_idx = i[2:0]; cset_value = v[0];
        ld_valid = 1; ld_safe_op = 1; ld_cr = i[2:0];
        #1 chk("R2", "same-cycle bypass", ld_bypass, cr_m[i]);
        @(posedge clk); #1;
        if (cr_m[i]) sc_m++; else qc_m++;
        cr_m[i] = v[0];
        idle();
        load(1, 0, i, 0, "R2");
      end
    end
    // R3: writes to index 0 ignored
    cset(0, 0, 0);
    load(1, 0, 0, 1, "R3");
    for (int i = 1; i < NCR; i++) cset(i, 1, 0);
    for (int i = 1; i < NCR; i++) load(1, 0, i, 0, "R2");
    // R4: clear wins over same-cycle write
    cset(3, 1, 1);
    for (int i = 0; i < NCR; i++) load(1, 0, i, 0, "R4");
    // R5 / R6: full load queue
    cset(5, 1, 0);
    load(1, 0, 5, 1, "R5");
    load(1, 0, 6, 1, "R6");
    load(0, 0, 5, 0, "R6");
    load(0, 0, 5, 1, "R6");
    state("R9");
    // R7 / R8: fill store queue, mix of safe and unsafe
    for (int i = 0; i < SQD; i++) begin
      store(1, i, (i % 3) != 0, 0, 0, 0, 0);
      state("R7");
      load(1, 1, 0, 1, "R5");
    end
    // R10: dispatch to occupied slot, retire/squash same slot
    store(1, 3, 0, 0, 0, 0, 0);
    state("R10");
    store(0, 0, 0, 1, 0, 1, 0);
    state("R10");
    store(0, 0, 0, 1, 0, 0, 0);
    state("R10");
    // R7: retire and squash together with a dispatch in one cycle
    store(1, 0, 0, 1, 3, 1, 6);
    state("R7");
    for (int i = 0; i < SQD; i++) begin
      if (i % 2 == 0) store(0, 0, 0, 1, i, 0, 0);
      else            store(0, 0, 0, 0, 0, 1, i);
      state("R7");
      load(1, 1, 0, 0, "R8");
    end
    store(0, 0, 0, 1, 2, 1, 4);
    state("R10");
    load(1, 1, 7, 1, "R8");
    state("R9");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule